// File: doc/BRIEF.md
# Reset Sequence Manager

This block merges three reset requests into one internal reset for the clock domain. It also drives a shared bidirectional reset pin, which it can only pull low; an external weak pull-up supplies the high level. The three requests are an active-low level on that pin, a digital low-supply indication from a hysteresis comparator, and a single-cycle watchdog underflow pulse.

An external low level counts only after it has been seen for a minimum number of synchronized cycles. Supply-low indications shorter than a glitch window are dropped. Every accepted request pulls the pin low for a guaranteed minimum width, so a short external pulse is stretched. A long external pulse is followed to its end with no added delay, and the block's own drive never re-triggers recognition. The internal reset is released through a synchronizer tail once the pin reads high and no request is active.

A sticky cause register keeps the most recent accepted source. Only a supply-low reset overwrites it with the supply code.

Top module: `rst_seq_mgr`

## Requirements
- R1: While `rst` is high, and on leaving it, `pin_oe` and `sys_rst` are 1 and `cause` is 1 (supply). The pin is then driven low for at least `T_OUT` cycles.
- R2: An external low level held for fewer than `T_IN` clock cycles is ignored. `pin_oe` and `sys_rst` stay 0.
- R3: An external low level held for `T_IN` cycles or more, and released before the stretch ends, makes `pin_oe` high for exactly `T_OUT` consecutive cycles.
- R4: An external low level still present when the stretch ends gives a single `T_OUT` drive with no re-trigger. `sys_rst` goes low at the `SYNC_STAGES+3`-th rising edge after the pin is released.
- R5: A watchdog pulse makes `pin_oe` high from the next edge for `T_OUT` cycles. A pulse that arrives during a drive restarts the `T_OUT` window from its edge.
- R6: A supply-low indication shorter than `T_LVD` cycles causes no drive and no reset.
- R7: A supply-low indication of `T_LVD` cycles or more drives the pin while it lasts. The drive then continues for `T_OUT` cycles counted from the first edge at which the synchronized indication reads clear.
- R8: `cause` encodes 1 = supply, 2 = external, 3 = watchdog. It is updated only when a source is accepted, with priority supply > watchdog > external in one cycle, and it changes only while `sys_rst` is asserted.
- R9: `sys_rst` is 1 whenever `pin_oe` is 1. With the pin high and no source active, it goes low at the `SYNC_STAGES+3`-th rising edge after `pin_oe` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high initialisation (power-up) |
| pin_in | input | 1 | Read-back level of the shared reset pin (0 = low) |
| lvd_low | input | 1 | Supply-low comparator output, 1 = supply below threshold |
| wdg_uf | input | 1 | Single-cycle watchdog underflow pulse |
| pin_oe | output | 1 | 1 = pull the reset pin low; never drives high |
| sys_rst | output | 1 | Internal active-high reset |
| cause | output | 2 | Most recent accepted reset source |

## Verification
The watchdog pulse and external-pin recognition can land in the same cycle. A watchdog pulse can also arrive in the middle of a stretch that an external pulse started. The bench provokes both by timing the watchdog pulse to the edge at which an external pulse of exactly `T_IN` cycles is accepted, and to a later edge inside the drive. It judges them by the total drive length, computed arithmetically from the restart edge, and by the cause code, which must read watchdog in both cases.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DRIVE  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_HOLD   = 2'd3
  } rsm_state_e;

  localparam logic [1:0] CAUSE_LVD = 2'd1;
  localparam logic [1:0] CAUSE_EXT = 2'd2;
  localparam logic [1:0] CAUSE_WDG = 2'd3;
endpackage

// File: rtl/rsm_sync.sv
module rsm_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= {STAGES{RST_VAL}};
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/rsm_run_filter.sv
// Fires on the WIDTH-th consecutive enabled cycle with level high.
module rsm_run_filter #(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic level,
  output logic hit
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [CW-1:0] cnt;

  assign hit = en & level & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en || !level) cnt <= '0;
    else if (cnt != LAST)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rsm_seq_fsm.sv
module rsm_seq_fsm #(
  parameter int T_OUT       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_int,
  input  logic ext_hit,
  input  logic pin_low_s,
  output logic idle,
  output logic drive,
  output logic rst_out
);
  import rsm_pkg::*;

  localparam int CW = $clog2(T_OUT + 1);
  localparam logic [CW-1:0] RELOAD = CW'(T_OUT - 1);
  localparam int SW = $clog2(SYNC_STAGES + 1);
  localparam logic [SW-1:0] SLOAD = SW'(SYNC_STAGES);

  rsm_state_e state, nxt;
  logic [CW-1:0] cnt;
  logic [SW-1:0] scnt;
  logic [SYNC_STAGES-1:0] tail;
  logic rst_q;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (trig_int || ext_hit) nxt = ST_DRIVE;
      ST_DRIVE:  if (!trig_int && cnt == '0) nxt = ST_SETTLE;
      ST_SETTLE: begin
        if (trig_int)         nxt = ST_DRIVE;
        else if (scnt == '0)  nxt = pin_low_s ? ST_HOLD : ST_IDLE;
      end
      ST_HOLD: begin
        if (trig_int)         nxt = ST_DRIVE;
        else if (!pin_low_s)  nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_DRIVE;
      cnt   <= RELOAD;
      scnt  <= '0;
      tail  <= '1;
      rst_q <= 1'b1;
    end else begin
      state <= nxt;
      if (nxt == ST_DRIVE && (state != ST_DRIVE || trig_int)) cnt <= RELOAD;
      else if (state == ST_DRIVE && cnt != '0)                cnt <= cnt - 1'b1;
      if (nxt == ST_SETTLE && state != ST_SETTLE) scnt <= SLOAD;
      else if (scnt != '0)                        scnt <= scnt - 1'b1;
      if (nxt != ST_IDLE) tail <= '1;
      else                tail <= {tail[SYNC_STAGES-2:0], 1'b0};
      rst_q <= (nxt != ST_IDLE) | tail[SYNC_STAGES-1];
    end
  end

  assign idle    = (state == ST_IDLE);
  assign drive   = (state == ST_DRIVE);
  assign rst_out = rst_q;
endmodule

// File: rtl/rst_seq_mgr.sv
module rst_seq_mgr #(
  parameter int T_IN        = 4,
  parameter int T_OUT       = 16,
  parameter int T_LVD       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_in,
  input  logic       lvd_low,
  input  logic       wdg_uf,
  output logic       pin_oe,
  output logic       sys_rst,
  output logic [1:0] cause
);
  import rsm_pkg::*;

  logic pin_s, lvd_s, pin_low_s;
  logic idle, ext_hit, lvd_hit, lvd_act, trig_int;
  logic [1:0] cause_q;

  rsm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s));

  rsm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_lvd_sync (
    .clk(clk), .rst(rst), .d(lvd_low), .q(lvd_s));

  assign pin_low_s = ~pin_s;

  rsm_run_filter #(.WIDTH(T_IN)) u_ext_filt (
    .clk(clk), .rst(rst), .en(idle), .level(pin_low_s), .hit(ext_hit));

  rsm_run_filter #(.WIDTH(T_LVD)) u_lvd_filt (
    .clk(clk), .rst(rst), .en(~lvd_act), .level(lvd_s), .hit(lvd_hit));

  always_ff @(posedge clk) begin
    if (rst)                     lvd_act <= 1'b1;
    else if (lvd_act && !lvd_s)  lvd_act <= 1'b0;
    else if (lvd_hit)            lvd_act <= 1'b1;
  end

  assign trig_int = wdg_uf | lvd_act | lvd_hit;

  rsm_seq_fsm #(.T_OUT(T_OUT), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
    .clk(clk), .rst(rst), .trig_int(trig_int), .ext_hit(ext_hit),
    .pin_low_s(pin_low_s), .idle(idle), .drive(pin_oe), .rst_out(sys_rst));

  always_ff @(posedge clk) begin
    if (rst)          cause_q <= CAUSE_LVD;
    else if (lvd_hit) cause_q <= CAUSE_LVD;
    else if (wdg_uf)  cause_q <= CAUSE_WDG;
    else if (ext_hit) cause_q <= CAUSE_EXT;
  end

  assign cause = cause_q;
endmodule

// File: rtl/rsm_checker.sv
module rsm_checker #(
  parameter int T_OUT = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       wdg_uf,
  input logic       pin_oe,
  input logic       sys_rst,
  input logic [1:0] cause
);
  int unsigned oe_len;

  always_ff @(posedge clk) begin
    if (rst)         oe_len <= 0;
    else if (pin_oe) oe_len <= oe_len + 1;
    else             oe_len <= 0;
  end

  AST_OE_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(pin_oe) |-> (oe_len >= T_OUT)); // R3

  AST_RST_COVERS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    pin_oe |-> sys_rst); // R9

  AST_RST_FALL_AFTER_DRIVE: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst) |-> !pin_oe); // R9

  AST_WDG_DRIVES_PIN: assert property (@(posedge clk) disable iff (rst)
    wdg_uf |=> pin_oe); // R5

  AST_CAUSE_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    !$stable(cause) |-> sys_rst); // R8
endmodule

bind rst_seq_mgr rsm_checker #(.T_OUT(T_OUT)) u_chk (.*);

// File: tb/rst_seq_mgr_tb.sv
module rst_seq_mgr_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int T_IN        = 4;
  localparam int T_OUT       = 16;
  localparam int T_LVD       = 6;
  localparam int SYNC_STAGES = 2;

  logic clk = 1'b0;
  logic rst, ext_low, lvd_low, wdg_uf;
  logic pin_in, pin_oe, sys_rst;
  logic [1:0] cause;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pin_in = ~(ext_low | pin_oe);

  rst_seq_mgr #(.T_IN(T_IN), .T_OUT(T_OUT), .T_LVD(T_LVD), .SYNC_STAGES(SYNC_STAGES)) u_dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .lvd_low(lvd_low), .wdg_uf(wdg_uf),
    .pin_oe(pin_oe), .sys_rst(sys_rst), .cause(cause));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int win, input int ext_len, input int lvd_len, input int wdg_at,
                         output int oe_tot, output int oe_fall, output int sr_fall,
                         output int sr_seen);
    logic p_oe, p_sr;
    oe_tot = 0; oe_fall = -1; sr_fall = -1; sr_seen = 0;
    p_oe = pin_oe; p_sr = sys_rst;
    for (int i = 0; i < win; i++) begin
      ext_low = (i < ext_len);
      lvd_low = (i < lvd_len);
      wdg_uf  = (i == wdg_at);
      @(negedge clk);
      if (pin_oe) oe_tot++;
      if (sys_rst) sr_seen = 1;
      if (p_oe && !pin_oe) oe_fall = i;
      if (p_sr && !sys_rst) sr_fall = i;
      p_oe = pin_oe; p_sr = sys_rst;
    end
    ext_low = 1'b0; lvd_low = 1'b0; wdg_uf = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int oe_tot, oe_fall, sr_fall, sr_seen, exp_oe;
    rst = 1'b1; ext_low = 1'b0; lvd_low = 1'b0; wdg_uf = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pin_oe in reset", int'(pin_oe), 1);
    chk("R1 sys_rst in reset", int'(sys_rst), 1);
    chk("R1 cause in reset", int'(cause), 1);
    rst = 1'b0;
    measure(60, 0, 0, -1, oe_tot, oe_fall, sr_fall, sr_seen);
    chk("R1 power-up drive >= T_OUT", int'(oe_tot >= T_OUT), 1);
    chk("R9 release tail after power-up", sr_fall - oe_fall, SYNC_STAGES + 3);
    chk("R9 sys_rst low after power-up", int'(sys_rst), 0);

    // external pulse length sweep: R2, R3, R4
    for (int n = 1; n <= T_IN + T_OUT + 12; n++) begin
      measure(n + T_OUT + 24, n, 0, -1, oe_tot, oe_fall, sr_fall, sr_seen);
      exp_oe = (n >= T_IN) ? T_OUT : 0;
      if (n < T_IN) begin
        chk("R2 short external pulse no drive", oe_tot, 0);
        chk("R2 short external pulse no reset", sr_seen, 0);
      end else begin
        chk("R3 external drive width", oe_tot, exp_oe);
        chk("R8 cause after external", int'(cause), 2);
        if (n <= T_IN + 2)
          chk("R9 release tail after stretch", sr_fall - oe_fall, SYNC_STAGES + 3);
        if (n >= T_IN + T_OUT + 8) begin
          chk("R4 long pulse single drive", oe_tot, T_OUT);
          chk("R4 release follows pin", sr_fall - n, SYNC_STAGES + 2);
        end
      end
      chk("R9 quiet at window end", int'(sys_rst), 0);
    end

    // watchdog alone: R5
    measure(T_OUT + 24, 0, 0, 0, oe_tot, oe_fall, sr_fall, sr_seen);
    chk("R5 watchdog drive width", oe_tot, T_OUT);
    chk("R8 cause after watchdog", int'(cause), 3);
    chk("R9 release tail after watchdog", sr_fall - oe_fall, SYNC_STAGES + 3);

    // ignored external pulse must not disturb cause: R8, R2
    measure(T_OUT + 10, T_IN - 1, 0, -1, oe_tot, oe_fall, sr_fall, sr_seen);
    chk("R2 rejected pulse no drive", oe_tot, 0);
    chk("R8 cause kept after rejected pulse", int'(cause), 3);

    // watchdog during an external stretch, and on its acceptance edge: R5, R8
    for (int k = 0; k < 2; k++) begin
      int wat;
      wat = (k == 0) ? 10 : T_IN + 1;
      measure(T_OUT + 40, T_IN, 0, wat, oe_tot, oe_fall, sr_fall, sr_seen);
      chk("R5 watchdog restarts stretch", oe_tot, (wat + 1) - (T_IN + 2) + T_OUT);
      chk("R8 watchdog wins over external", int'(cause), 3);
    end

    // supply-low sweep: R6, R7
    for (int l = 1; l <= T_LVD + 3; l++) begin
      measure(l + T_OUT + 24, 0, l, -1, oe_tot, oe_fall, sr_fall, sr_seen);
      if (l < T_LVD) begin
        chk("R6 short supply glitch no drive", oe_tot, 0);
        chk("R6 short supply glitch no reset", sr_seen, 0);
        chk("R8 cause kept after glitch", int'(cause), 3);
      end else begin
        chk("R7 supply-low drive width", oe_tot, T_OUT + l + 1 - T_LVD);
        chk("R8 cause after supply-low", int'(cause), 1);
      end
    end

    // external after supply-low overwrites with external code: R8
    measure(T_OUT + 30, T_IN + 1, 0, -1, oe_tot, oe_fall, sr_fall, sr_seen);
    chk("R8 cause external after supply", int'(cause), 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule